// File: doc/BRIEF.md
# Ping-Pong Word-to-Halfword Line Buffer

This block sits between a memory-reading engine that delivers 32-bit words and a consumer that takes one 16-bit pixel at a time. It holds two buffer sets. Each set pairs a word queue with a pixel queue, and a splitter moves each word into the pixel queue as two pixels. Incoming words fill one set for a whole row. After a parameterised number of words the writer moves to the other set, so each row lands in alternate sets.

The consumer reads from one set while the other set is being filled. A line-boundary pulse swaps the set it reads from. A read from an empty pixel queue returns zero and raises an underflow flag, which stays set until reset. With the default parameters a row is 320 words (640 pixels), a word queue holds 512 entries and a pixel queue holds 1024.

Top module: `pingpong_line_buf`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) empties all four queues, selects set 0 for writing and reading (`wr_set` = 0, `rd_set` = 0), clears `pix_out` and `underflow`, and leaves `in_ready` high.
- R2: A word is taken only in a cycle with `in_valid` and `in_ready` both high. It goes into the set shown by `wr_set`. After `LINE_WORDS` accepted words `wr_set` toggles, and it does not change in any other cycle.
- R3: Each accepted word leaves its set as two pixels: bits 31:16 first, then bits 15:0. Words come out in the order they were accepted.
- R4: `in_ready` is low while the word queue of the current write set is full. A word offered while `in_ready` is low is discarded and never appears at `pix_out`.
- R5: The splitter starts a word only when its pixel queue has at least two free entries. Filling a set to capacity therefore loses no pixel and does not reorder pixels. With no reads, a set holds `WORD_DEPTH + PIX_DEPTH/2` words.
- R6: A cycle with `pix_rd` high removes one pixel from the set shown by `rd_set`, and that pixel appears on `pix_out` after that clock edge. In cycles without `pix_rd`, `pix_out` holds its value.
- R7: A cycle with `line_sync` high toggles `rd_set` after the edge. A read in that same cycle is served from the set that was selected before the toggle.
- R8: A read from an empty pixel queue drives `pix_out` to 0 and sets `underflow`. Once set, `underflow` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Incoming word is present |
| in_word | input | WORD_W | Incoming word, upper half is the earlier pixel |
| in_ready | output | 1 | Current write set can take a word |
| wr_set | output | 1 | Set that receives incoming words |
| pix_rd | input | 1 | Consumer takes one pixel |
| line_sync | input | 1 | Line boundary, swaps the read set |
| pix_out | output | WORD_W/2 | Last pixel read, 0 after a read from empty |
| underflow | output | 1 | Sticky flag, a read found its queue empty |
| rd_set | output | 1 | Set the consumer reads from |

## Verification
A read and a line-boundary pulse can fall in the same cycle, and the test has to show that the pixel comes from the old set and only later reads use the new one. The bench provokes this directly while both sets hold different data, and it also raises `line_sync` at random alongside random reads. A bench queue model, which swaps its read pointer only after serving the read, judges the result. A second collision is the splitter pushing into a pixel queue in the same cycle the consumer pops it. Back-to-back reads on a full set provoke it, and the check is that the pixel sequence arrives intact, with nothing lost or duplicated.

// File: rtl/pp_pkg.sv
package pp_pkg;
   localparam int unsigned SETS = 2;

   function automatic logic [15:0] upper_pix(input logic [31:0] w);
      return w[31:16];
   endfunction

   function automatic logic [15:0] lower_pix(input logic [31:0] w);
      return w[15:0];
   endfunction
endpackage

// File: rtl/pp_fifo.sv
module pp_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 8,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic          empty,
   output logic          full,
   output logic [CW-1:0] free
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("pp_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [CW-1:0] count;
   logic          do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign free    = CW'(DEPTH) - count;
   assign dout    = mem[rptr];
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
         if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/pp_splitter.sv
module pp_splitter #(
   parameter int WORD_W = 32,
   parameter int CW     = 4,
   localparam int PIX_W = WORD_W / 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              word_empty,
   input  logic [WORD_W-1:0] word_head,
   input  logic [CW-1:0]     pix_free,
   output logic              word_pop,
   output logic              pix_push,
   output logic [PIX_W-1:0]  pix_data
);
   logic low_phase;
   logic start;

   assign start = !low_phase && !word_empty && (pix_free >= CW'(2));

   always_comb begin
      word_pop = 1'b0;
      pix_push = 1'b0;
      pix_data = word_head[WORD_W-1:PIX_W];
      if (low_phase) begin
         pix_push = 1'b1;
         word_pop = 1'b1;
         pix_data = word_head[PIX_W-1:0];
      end else if (start) begin
         pix_push = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)            low_phase <= 1'b0;
      else if (low_phase) low_phase <= 1'b0;
      else if (start)     low_phase <= 1'b1;
   end
endmodule

// File: rtl/pp_rd_port.sv
module pp_rd_port #(
   parameter int PIX_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             pix_rd,
   input  logic             line_sync,
   input  logic             sel_empty,
   input  logic [PIX_W-1:0] sel_head,
   output logic             rd_set,
   output logic [PIX_W-1:0] pix_out,
   output logic             underflow
);
   always_ff @(posedge clk) begin
      if (rst) begin
         rd_set    <= 1'b0;
         pix_out   <= '0;
         underflow <= 1'b0;
      end else begin
         if (line_sync) rd_set <= !rd_set;
         if (pix_rd) begin
            pix_out <= sel_empty ? '0 : sel_head;
            if (sel_empty) underflow <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/pingpong_line_buf.sv
module pingpong_line_buf #(
   parameter int WORD_W     = 32,
   parameter int WORD_DEPTH = 512,
   parameter int PIX_DEPTH  = 1024,
   parameter int LINE_WORDS = 320,
   localparam int PIX_W     = WORD_W / 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_word,
   output logic              in_ready,
   output logic              wr_set,
   input  logic              pix_rd,
   input  logic              line_sync,
   output logic [PIX_W-1:0]  pix_out,
   output logic              underflow,
   output logic              rd_set
);
   import pp_pkg::*;

   localparam int LCW = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1;
   localparam int PCW = $clog2(PIX_DEPTH + 1);
   localparam int WCW = $clog2(WORD_DEPTH + 1);

   if (WORD_W % 2 != 0) begin : g_bad_width
      $error("pingpong_line_buf: WORD_W must be even");
   end
   if (PIX_DEPTH < 2) begin : g_bad_pix
      $error("pingpong_line_buf: PIX_DEPTH must hold one whole word");
   end
   if (LINE_WORDS < 1) begin : g_bad_line
      $error("pingpong_line_buf: LINE_WORDS must be positive");
   end

   logic [LCW-1:0]    line_cnt;
   logic              accept;
   logic [SETS-1:0]   w_empty, w_full, w_pop, w_push;
   logic [SETS-1:0]   p_empty, p_push, p_pop;
   logic [WORD_W-1:0] w_head [SETS];
   logic [PIX_W-1:0]  p_head [SETS];
   logic [PIX_W-1:0]  p_din  [SETS];
   logic [PCW-1:0]    p_free [SETS];
   logic [WCW-1:0]    w_free [SETS];

   assign in_ready = !w_full[wr_set];
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_set   <= 1'b0;
         line_cnt <= '0;
      end else if (accept) begin
         if (line_cnt == LCW'(LINE_WORDS - 1)) begin
            line_cnt <= '0;
            wr_set   <= !wr_set;
         end else begin
            line_cnt <= line_cnt + 1'b1;
         end
      end
   end

   for (genvar s = 0; s < SETS; s++) begin : g_set
      assign w_push[s] = accept && (wr_set == 1'(s));
      assign p_pop[s]  = pix_rd && (rd_set == 1'(s));

      pp_fifo #(.W(WORD_W), .DEPTH(WORD_DEPTH)) u_wq (
         .clk(clk), .rst(rst),
         .push(w_push[s]), .din(in_word),
         .pop(w_pop[s]), .dout(w_head[s]),
         .empty(w_empty[s]), .full(w_full[s]), .free(w_free[s])
      );

      pp_splitter #(.WORD_W(WORD_W), .CW(PCW)) u_split (
         .clk(clk), .rst(rst),
         .word_empty(w_empty[s]), .word_head(w_head[s]),
         .pix_free(p_free[s]),
         .word_pop(w_pop[s]), .pix_push(p_push[s]), .pix_data(p_din[s])
      );

      logic p_full_unused;
      pp_fifo #(.W(PIX_W), .DEPTH(PIX_DEPTH)) u_pq (
         .clk(clk), .rst(rst),
         .push(p_push[s]), .din(p_din[s]),
         .pop(p_pop[s]), .dout(p_head[s]),
         .empty(p_empty[s]), .full(p_full_unused), .free(p_free[s])
      );
   end

   pp_rd_port #(.PIX_W(PIX_W)) u_rd (
      .clk(clk), .rst(rst),
      .pix_rd(pix_rd), .line_sync(line_sync),
      .sel_empty(p_empty[rd_set]), .sel_head(p_head[rd_set]),
      .rd_set(rd_set), .pix_out(pix_out), .underflow(underflow)
   );
endmodule

// File: rtl/pp_checker.sv
module pp_checker #(
   parameter int PIX_W = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic             in_ready,
   input logic             wr_set,
   input logic             pix_rd,
   input logic             line_sync,
   input logic [PIX_W-1:0] pix_out,
   input logic             underflow,
   input logic             rd_set
);
   a_r2_wrset_only_on_accept: assert property (@(posedge clk) disable iff (rst)
      !(in_valid && in_ready) |=> $stable(wr_set));

   a_r6_pix_holds: assert property (@(posedge clk) disable iff (rst)
      !pix_rd |=> $stable(pix_out));

   a_r7_sync_toggles: assert property (@(posedge clk) disable iff (rst)
      line_sync |=> (rd_set != $past(rd_set)));

   a_r7_rdset_holds: assert property (@(posedge clk) disable iff (rst)
      !line_sync |=> $stable(rd_set));

   a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
      underflow |=> underflow);

   a_r8_rise_needs_read: assert property (@(posedge clk) disable iff (rst)
      !underflow |=> (!underflow || $past(pix_rd)));

   a_r8_zero_on_rise: assert property (@(posedge clk) disable iff (rst)
      $rose(underflow) |-> (pix_out == '0));
endmodule

bind pingpong_line_buf pp_checker #(.PIX_W(PIX_W)) u_chk (.*);

// File: tb/sim_pingpong_line_buf.sv
module sim_pingpong_line_buf;
   localparam int WW = 32;
   localparam int PW = 16;
   localparam int WD = 4;
   localparam int PD = 8;
   localparam int LW = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic [WW-1:0] in_word = '0;
   logic          in_ready, wr_set, underflow, rd_set;
   logic          pix_rd = 1'b0;
   logic          line_sync = 1'b0;
   logic [PW-1:0] pix_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [PW-1:0] mq0[$];
   logic [PW-1:0] mq1[$];
   bit            m_wset, m_rset, m_uf;
   int            m_lcnt;
   logic [PW-1:0] m_pix;

   always #10 clk = !clk;

   pingpong_line_buf #(.WORD_W(WW), .WORD_DEPTH(WD), .PIX_DEPTH(PD), .LINE_WORDS(LW)) u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready),
      .wr_set(wr_set), .pix_rd(pix_rd), .line_sync(line_sync), .pix_out(pix_out),
      .underflow(underflow), .rd_set(rd_set));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [PW-1:0] hi_of(input logic [WW-1:0] w);
      return w[WW-1:PW];
   endfunction
   function automatic logic [PW-1:0] lo_of(input logic [WW-1:0] w);
      return w[PW-1:0];
   endfunction

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic model_reset();
      mq0.delete(); mq1.delete();
      m_wset = 0; m_rset = 0; m_uf = 0; m_lcnt = 0; m_pix = '0;
   endtask

   task automatic do_reset();
      rst = 1'b1; in_valid = 0; pix_rd = 0; line_sync = 0;
      tick(); tick();
      rst = 1'b0;
      model_reset();
      // R1: reset state
      chk(wr_set == 0 && rd_set == 0, "R1 set selects", {wr_set, rd_set}, 0);
      chk(pix_out == 0 && underflow == 0, "R1 output and flag", {pix_out, 3'b0, underflow}, 0);
      chk(in_ready == 1, "R1 in_ready", in_ready, 1);
   endtask

   task automatic do_write(input logic [WW-1:0] w, output bit acc);
      in_valid = 1'b1; in_word = w;
      acc = in_ready;
      if (acc) begin
         if (m_wset) begin mq1.push_back(hi_of(w)); mq1.push_back(lo_of(w)); end
         else        begin mq0.push_back(hi_of(w)); mq0.push_back(lo_of(w)); end
         m_lcnt++;
         if (m_lcnt == LW) begin m_lcnt = 0; m_wset = !m_wset; end
      end
      tick();
      in_valid = 1'b0;
      // R2: write set follows accepted word count
      chk(wr_set == m_wset, "R2 wr_set", wr_set, m_wset);
   endtask

   task automatic do_read(input bit ls);
      bit emp;
      pix_rd = 1'b1; line_sync = ls;
      emp = m_rset ? (mq1.size() == 0) : (mq0.size() == 0);
      if (emp) begin m_pix = '0; m_uf = 1; end
      else if (m_rset) m_pix = mq1.pop_front();
      else m_pix = mq0.pop_front();
      if (ls) m_rset = !m_rset;
      tick();
      pix_rd = 1'b0; line_sync = 1'b0;
      // R3/R6: pixel order and one-cycle read latency; R8 zero on empty
      chk(pix_out == m_pix, emp ? "R8 empty read pixel" : "R3 R6 pixel", pix_out, m_pix);
      chk(underflow == m_uf, "R8 underflow flag", underflow, m_uf);
      chk(rd_set == m_rset, "R7 rd_set", rd_set, m_rset);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         tick();
         chk(pix_out == m_pix, "R6 pix_out holds", pix_out, m_pix);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      bit acc;
      int n_acc;
      logic [WW-1:0] first_set1;
      void'($urandom(32'd20190722));
      @(negedge clk);
      do_reset();

      // R4/R5: fill both sets with no reads; capacity per set is WD + PD/2 words
      n_acc = 0;
      for (int i = 0; i < 60; i++) begin
         logic [WW-1:0] w = $urandom();
         if (n_acc == LW) first_set1 = w;
         do_write(w, acc);
         if (acc) n_acc++;
         if (!acc) idle(1);
      end
      chk(n_acc == 2 * (WD + PD / 2), "R5 total capacity", n_acc, 2 * (WD + PD / 2));
      chk(in_ready == 0, "R4 in_ready low when full", in_ready, 0);
      // R4: rejected words never appear; model only holds accepted ones
      in_valid = 1'b1; in_word = 32'hDEAD_BEEF; idle(3); in_valid = 1'b0;

      // R7: read and line_sync in the same cycle; served from old set
      do_read(1'b1);
      chk(rd_set == 1, "R7 switched to set 1", rd_set, 1);
      do_read(1'b0);
      chk(pix_out == hi_of(first_set1), "R3 R7 first pixel of set 1 is upper half", pix_out, hi_of(first_set1));
      // drain set 1 back to back (splitter push and consumer pop collide)
      while (mq1.size() > 0) do_read(1'b0);
      do_read(1'b1);
      chk(pix_out == 0 && underflow == 1, "R8 read from empty set 1", {pix_out, 3'b0, underflow}, 1);
      while (mq0.size() > 0) do_read(1'b0);
      idle(4);
      chk(underflow == 1, "R8 underflow sticky", underflow, 1);

      do_reset();

      // random phase: write bursts, settle, random reads with random line syncs
      for (int r = 0; r < 120; r++) begin
         int nw = $urandom_range(0, 10);
         for (int i = 0; i < nw; i++) begin
            do_write($urandom(), acc);
            if ($urandom_range(0, 3) == 0) idle(1);
         end
         idle(20);
         for (int i = 0; i < $urandom_range(0, 24); i++) begin
            do_read($urandom_range(0, 9) == 0);
            if ($urandom_range(0, 2) == 0) idle(1);
         end
         if (r == 60) do_reset();
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule